// File: doc/BRIEF.md
# Mirrored Converging LED Shifter

This block drives an LED bank with two lit positions that are always mirror images of each other. The two positions start at the outer ends and move one place toward the centre on each step. When they reach the centre they turn round and move back out to the ends. The pattern repeats for as long as the block is allowed to run.

A tick divider, set at build time by a parameter, produces the step rate from the system clock. A run input pauses both the pattern and the divider without losing their state. A one-cycle strobe marks each cycle in which a new pattern first appears. Reset is synchronous.

Top module: `led_mirror_shifter`

## Requirements
- R1: While reset is high at a clock edge, the LEDs show only the two outer bits after that edge (8'h81 for 8 LEDs), the strobe is low and the divider count returns to zero.
- R2: In every cycle exactly two LEDs are lit, and LED i is lit exactly when LED WIDTH-1-i is lit.
- R3: Successive steps move the lit pair inward one place at a time to the centre pair, then outward to the ends, then inward again. For 8 LEDs the patterns after reset are 81, 42, 24, 18, 24, 42, 81, 42 and so on, in hex. Each end pair and each centre pair is shown for only one step per pass.
- R4: The divider counts run-enabled cycles from 0 up to STEP_TICKS and then reloads to 0. A step happens on the cycle that finds the count equal to STEP_TICKS, so while run stays high the pattern changes once every STEP_TICKS+1 cycles.
- R5: The strobe is high for exactly one cycle: the first cycle in which a new pattern is visible. It is low in every other cycle.
- R6: While run is low, the LEDs and the divider count hold their values and no strobe is produced. When run goes high again, counting resumes from the held count, so the next step comes after only the remaining cycles.
- R7: A reset applied in the middle of a pass restores the state of R1, and the sequence then starts over from the outer ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables the divider and the pattern when high |
| leds_o | output | WIDTH | LED drive, one bit per LED, active high |
| step_o | output | 1 | One-cycle strobe in the first cycle of each new pattern |

## Verification
On every cycle, the embedded assertions check the following:
- exactly two LEDs are lit and they are mirror images of each other;
- the divider count stays in its range;
- the walker offset stays in its range and turns round at the centre;
- nothing changes while run is low;
- each strobe comes with a pattern that differs from the one before.

The order of the patterns, the exact spacing of STEP_TICKS+1 cycles and the resume-from-held-count behaviour after a pause depend on history over many cycles. Only the bench shows them. It does so by comparing the outputs on every clock with a behavioural model and by walking explicit sequences through reset, a pause and a mid-pass reset.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic {DIR_IN = 1'b0, DIR_OUT = 1'b1} dir_e;

  function automatic int walk_last(input int half);
    return half - 1;
  endfunction

  function automatic int width_for(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/lms_tick_divider.sv
module lms_tick_divider #(
  parameter int STEP_TICKS = 4,
  parameter int CNT_W      = lms_pkg::width_for(STEP_TICKS)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STEP_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == LIMIT);
  assign tick_o   = run && at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (run) begin
      if (at_limit) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
  a_r6_count_held: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt_q));
endmodule

// File: rtl/lms_bounce_walker.sv
module lms_bounce_walker #(
  parameter int HALF  = 4,
  parameter int OFF_W = lms_pkg::width_for(HALF - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [OFF_W-1:0] offset_o
);
  import lms_pkg::*;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(walk_last(HALF));

  dir_e             dir_q;
  logic [OFF_W-1:0] off_q;
  logic             at_centre, at_edge;

  assign at_centre = (off_q == LAST);
  assign at_edge   = (off_q == '0);
  assign offset_o  = off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
      dir_q <= DIR_IN;
    end else if (advance) begin
      if (dir_q == DIR_IN) begin
        if (at_centre) begin
          dir_q <= DIR_OUT;
          off_q <= off_q - 1'b1;
        end else begin
          off_q <= off_q + 1'b1;
        end
      end else begin
        if (at_edge) begin
          dir_q <= DIR_IN;
          off_q <= off_q + 1'b1;
        end else begin
          off_q <= off_q - 1'b1;
        end
      end
    end
  end

  a_r3_offset_in_range: assert property (@(posedge clk) disable iff (rst)
    off_q <= LAST);
  a_r3_turn_at_centre: assert property (@(posedge clk) disable iff (rst)
    (advance && at_centre) |=> (dir_q == DIR_OUT));
  a_r3_turn_at_edge: assert property (@(posedge clk) disable iff (rst)
    (advance && at_edge) |=> (dir_q == DIR_IN));
endmodule

// File: rtl/lms_mirror_decoder.sv
module lms_mirror_decoder #(
  parameter int WIDTH = 8,
  parameter int OFF_W = lms_pkg::width_for(WIDTH / 2 - 1)
) (
  input  logic [OFF_W-1:0] offset_i,
  output logic [WIDTH-1:0] mask_o
);
  localparam int HALF = WIDTH / 2;

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    assign mask_o[i]           = (offset_i == OFF_W'(i));
    assign mask_o[WIDTH-1-i]   = (offset_i == OFF_W'(i));
  end
endmodule

// File: rtl/led_mirror_shifter.sv
module led_mirror_shifter #(
  parameter int WIDTH      = 8,
  parameter int STEP_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [WIDTH-1:0] leds_o,
  output logic             step_o
);
  localparam int HALF  = WIDTH / 2;
  localparam int OFF_W = lms_pkg::width_for(HALF - 1);

  logic             tick;
  logic [OFF_W-1:0] offset;
  logic             step_q;

  initial begin
    assert (WIDTH >= 4 && WIDTH % 2 == 0)
      else $error("WIDTH must be even and at least 4");
  end

  lms_tick_divider #(.STEP_TICKS(STEP_TICKS)) u_div (
    .clk(clk), .rst(rst), .run(run), .tick_o(tick));

  lms_bounce_walker #(.HALF(HALF), .OFF_W(OFF_W)) u_walk (
    .clk(clk), .rst(rst), .advance(tick), .offset_o(offset));

  lms_mirror_decoder #(.WIDTH(WIDTH), .OFF_W(OFF_W)) u_dec (
    .offset_i(offset), .mask_o(leds_o));

  always_ff @(posedge clk) begin
    if (rst) step_q <= 1'b0;
    else     step_q <= tick;
  end
  assign step_o = step_q;

  a_r2_two_lit: assert property (@(posedge clk) disable iff (rst)
    $countones(leds_o) == 2);
  a_r2_mirrored: assert property (@(posedge clk) disable iff (rst)
    leds_o == {<<{leds_o}});
  a_r5_step_brings_change: assert property (@(posedge clk) disable iff (rst)
    tick |=> (step_o && leds_o != $past(leds_o)));
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(leds_o) && !step_o));
endmodule

// File: tb/led_mirror_shifter_bench.sv
module led_mirror_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int ST = 3;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0;
  logic [W-1:0] leds;
  logic step;

  int checks = 0, fails = 0, cycles = 0;
  int ref_cnt = 0, ref_k = 0, ref_out = 0;
  bit ref_step = 0, started = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_mirror_shifter #(.WIDTH(W), .STEP_TICKS(ST)) u_led_mirror_shifter (
    .clk(clk), .rst(rst), .run(run), .leds_o(leds), .step_o(step));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] ref_leds();
    logic [W-1:0] v = '0;
    v[ref_k] = 1'b1;
    v[W-1-ref_k] = 1'b1;
    return v;
  endfunction

  // behavioural model, one update per clock
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      started = 1; ref_cnt = 0; ref_k = 0; ref_out = 0; ref_step = 0;
    end else begin
      ref_step = 0;
      if (run) begin
        if (ref_cnt == ST) begin
          ref_cnt = 0; ref_step = 1;
          if (ref_out == 0) begin
            if (ref_k == W/2-1) begin ref_out = 1; ref_k--; end else ref_k++;
          end else begin
            if (ref_k == 0) begin ref_out = 0; ref_k++; end else ref_k--;
          end
        end else ref_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(leds === ref_leds(), "R2/R3/R4 model leds", leds, ref_leds());
      chk(step === ref_step, "R5 model strobe", {{(W-1){1'b0}}, step}, {{(W-1){1'b0}}, ref_step});
    end
  end

  initial begin
    logic [W-1:0] seq [7] = '{8'h81, 8'h42, 8'h24, 8'h18, 8'h24, 8'h42, 8'h81};
    logic [W-1:0] held;
    int gap;
    repeat (3) @(negedge clk);
    chk(leds === 8'h81, "R1 reset leds", leds, 8'h81);
    chk(step === 1'b0, "R1 reset strobe", {7'b0, step}, 8'h00);
    rst = 1'b0; run = 1'b1;
    // R3 order and R4 spacing
    for (int s = 1; s < 13; s++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!step && gap < 50);
      chk(leds === seq[s % 6], "R3 step pattern", leds, seq[s % 6]);
      chk(gap == ST + 1, "R4 step spacing", W'(gap), W'(ST + 1));
    end
    // R6 pause two cycles into an interval
    @(negedge clk); @(negedge clk);
    run = 1'b0; held = leds;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk(leds === held && !step, "R6 frozen while paused", leds, held);
    end
    run = 1'b1;
    gap = 0;
    do begin @(negedge clk); gap++; end while (!step && gap < 50);
    chk(gap == ST - 1, "R6 resume from held count", W'(gap), W'(ST - 1));
    // R7 mid-pass reset
    @(negedge clk); @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(leds === 8'h81 && !step, "R7 mid-pass reset", leds, 8'h81);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!step && gap < 50);
    chk(leds === 8'h42 && gap == ST + 1, "R7 restart sequence", leds, 8'h42);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule